// File: doc/BRIEF.md
# Receive Ring DMA Control Word

This block holds the single 32-bit control and status word of a receive DMA engine that walks a circular ring of descriptor tables. Software owns the ring's producer index, the run bit and a set of per-cause interrupt enables. Hardware owns the consumer index, which it advances as the engine finishes descriptor chains. It watches for the two indices meeting, and it folds every enabled cause into one sticky interrupt line.

The word sits at byte address 0x0C of a simple synchronous register port. Writes take effect on the clock edge, and reads return the word combinationally. The engine reports each finished descriptor entry with a one-cycle strobe plus qualifier flags. It reports DMA errors and DMA completion on separate strobes, and it reports whether a transfer is in flight. The block tells the engine whether it may run.

Top module: `rxring_ctrl_reg`

## Requirements
- R1: After reset the word at byte address 0x0C reads 0x40000000; a read at any other address returns 0, and a write at any other address changes nothing.
- R2: Writing 1 to bit 31 while the block is idle makes bit 31 read 1 for exactly one cycle. On the next edge both ring indices (bits 23:16 and 15:8) become 0x00 and bit 31 returns to 0.
- R3: A write of 1 to bit 31 while the run bit (bit 0) is 1, or while `xfer_busy` is 1, is ignored: bit 31 stays 0 and neither index is cleared.
- R4: The consumer index in bits 15:8 increments by one, modulo 256, on each `desc_done` strobe that carries `desc_eop` while the run bit is 1. A strobe without `desc_eop`, a strobe while the run bit is 0, and any software write to bits 15:8 leave it unchanged.
- R5: The producer index in bits 23:16 and the control bits 29, 7, 5, 3, 2, 1 and 0 read back exactly what software last wrote. `eng_run` equals bit 0.
- R6: When bit 29 is 1 and an advance of the consumer index makes it equal to the producer index, the run bit clears on that edge. Later descriptor strobes then do not move the consumer index. With bit 29 at 0 the run bit stays set.
- R7: Bit 30 always reads 1. Bits 28:24, bit 6 and bit 4 always read 0, whatever is written.
- R8: With bit 3 set, the interrupt is raised whenever the two indices are equal. Unequal indices raise nothing.
- R9: The interrupt is also raised by the following events, each only while its enable is 1. Bit 2 enables a descriptor strobe carrying `desc_ioc` or `desc_err`. Bit 1 enables `dma_err`. Bit 5 enables a descriptor strobe carrying `desc_eof`. Bit 7 enables `dma_cpl`. Descriptor-strobe causes count only while the run bit is 1.
- R10: `irq` goes high one cycle after an enabled event and stays high until an `irq_clr` pulse. It drops one cycle after the clear, unless an enabled event arrives in the same cycle as the clear, in which case it stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data (combinational) |
| xfer_busy | input | 1 | Engine has a transfer in flight |
| desc_done | input | 1 | One descriptor entry consumed |
| desc_eop | input | 1 | Consumed entry ends a chain |
| desc_ioc | input | 1 | Consumed entry requests completion interrupt |
| desc_err | input | 1 | Consumed entry finished with error |
| desc_eof | input | 1 | Consumed entry ends a frame |
| dma_err | input | 1 | Read DMA error strobe |
| dma_cpl | input | 1 | DMA completion strobe |
| irq_clr | input | 1 | Clears all pending interrupt causes |
| eng_run | output | 1 | Engine may consume descriptors |
| irq | output | 1 | Combined interrupt |

## Verification
The consumer index is driven through more than a full wrap with chain-ending strobes, mixed with strobes that do not end a chain and strobes sent while stopped. This separates a correct modulo-256 step from a stuck or early-stepping index. Overflow stopping is tried at producer distances 1, 2, 5 and 255 with stop enabled, and once with stop disabled. These runs show whether the run bit clears exactly on the meeting advance. Each interrupt cause is fired alone with only its own enable set and then with every other enable set, so a swapped or missing enable shows up. Pointer-reset writes are issued when idle, while running and while a transfer is busy, to confirm the idle gate.

// File: rtl/rxring_pkg.sv
package rxring_pkg;
   // Field positions software decodes in the control word
   localparam int B_PRST     = 31;
   localparam int B_WBACK    = 30;
   localparam int B_SOO      = 29;
   localparam int B_WP_LO    = 16;
   localparam int B_RP_LO    = 8;
   localparam int B_IE_CPL   = 7;
   localparam int B_IE_EOF   = 5;
   localparam int B_IE_STALL = 3;
   localparam int B_IE_IOC   = 2;
   localparam int B_IE_ERR   = 1;
   localparam int B_START    = 0;

   // Interrupt cause indices
   localparam int C_STALL = 0;
   localparam int C_IOC   = 1;
   localparam int C_ERR   = 2;
   localparam int C_EOF   = 3;
   localparam int C_CPL   = 4;
   localparam int N_CAUSE = 5;
endpackage

// File: rtl/rxring_ptr.sv
module rxring_ptr #(
   parameter int PTR_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wp_we,
   input  logic [PTR_W-1:0] wp_in,
   input  logic             prst_req,
   input  logic             adv_req,
   output logic [PTR_W-1:0] rptr,
   output logic [PTR_W-1:0] wptr,
   output logic             prst_busy,
   output logic             ptr_eq,
   output logic             ovf_hit
);
   logic             adv;
   logic [PTR_W-1:0] rptr_nx;

   assign adv     = adv_req && !prst_busy;
   assign rptr_nx = rptr + PTR_W'(1);
   assign ptr_eq  = (rptr == wptr);
   assign ovf_hit = adv && (rptr_nx == wptr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rptr      <= '0;
         wptr      <= '0;
         prst_busy <= 1'b0;
      end else if (prst_busy) begin
         rptr      <= '0;
         wptr      <= '0;
         prst_busy <= 1'b0;
      end else begin
         if (prst_req) prst_busy <= 1'b1;
         if (wp_we)    wptr      <= wp_in;
         if (adv)      rptr      <= rptr_nx;
      end
   end
endmodule

// File: rtl/rxring_irq.sv
module rxring_irq #(
   parameter int N = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] evt,
   input  logic [N-1:0] en,
   input  logic         clr,
   output logic [N-1:0] pend,
   output logic         irq
);
   for (genvar i = 0; i < N; i++) begin : g_cause
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                pend[i] <= 1'b0;
         else if (evt[i] && en[i])  pend[i] <= 1'b1;
         else if (clr)              pend[i] <= 1'b0;
      end
   end

   assign irq = |pend;
endmodule

// File: rtl/rxring_ctrl_reg.sv
module rxring_ctrl_reg
   import rxring_pkg::*;
#(
   parameter int          ADDR_W   = 8,
   parameter int          PTR_W    = 8,
   parameter logic [7:0]  REG_ADDR = 8'h0C
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic              xfer_busy,
   input  logic              desc_done,
   input  logic              desc_eop,
   input  logic              desc_ioc,
   input  logic              desc_err,
   input  logic              desc_eof,
   input  logic              dma_err,
   input  logic              dma_cpl,
   input  logic              irq_clr,
   output logic              eng_run,
   output logic              irq
);
   localparam int PAD_W = 8 - PTR_W;

   if (PTR_W < 1 || PTR_W > 8) begin : g_bad_ptr
      $error("PTR_W must lie in 1..8");
   end
   if (ADDR_W < 4) begin : g_bad_addr
      $error("ADDR_W too small for the word address");
   end

   logic               hit, wr, idle, prst_req, adv_req;
   logic               start_q, soo_q;
   logic [N_CAUSE-1:0] en_q, evt, pend;
   logic [PTR_W-1:0]   rptr, wptr;
   logic               prst_busy, ptr_eq, ovf_hit;
   logic [7:0]         rp8, wp8;

   assign hit      = (reg_addr == ADDR_W'(REG_ADDR));
   assign wr       = reg_we && hit;
   assign idle     = !start_q && !xfer_busy;
   assign prst_req = wr && reg_wdata[B_PRST] && idle;
   assign adv_req  = desc_done && start_q && desc_eop;

   rxring_ptr #(.PTR_W(PTR_W)) u_ptr (
      .clk       (clk),
      .rst_n     (rst_n),
      .wp_we     (wr),
      .wp_in     (reg_wdata[B_WP_LO +: PTR_W]),
      .prst_req  (prst_req),
      .adv_req   (adv_req),
      .rptr      (rptr),
      .wptr      (wptr),
      .prst_busy (prst_busy),
      .ptr_eq    (ptr_eq),
      .ovf_hit   (ovf_hit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_q <= 1'b0;
         soo_q   <= 1'b0;
         en_q    <= '0;
      end else begin
         if (ovf_hit && soo_q) start_q <= 1'b0;
         else if (wr)          start_q <= reg_wdata[B_START];
         if (wr) begin
            soo_q          <= reg_wdata[B_SOO];
            en_q[C_STALL]  <= reg_wdata[B_IE_STALL];
            en_q[C_IOC]    <= reg_wdata[B_IE_IOC];
            en_q[C_ERR]    <= reg_wdata[B_IE_ERR];
            en_q[C_EOF]    <= reg_wdata[B_IE_EOF];
            en_q[C_CPL]    <= reg_wdata[B_IE_CPL];
         end
      end
   end

   always_comb begin
      evt          = '0;
      evt[C_STALL] = ptr_eq;
      evt[C_IOC]   = desc_done && start_q && (desc_ioc || desc_err);
      evt[C_ERR]   = dma_err;
      evt[C_EOF]   = desc_done && start_q && desc_eof;
      evt[C_CPL]   = dma_cpl;
   end

   rxring_irq #(.N(N_CAUSE)) u_irq (
      .clk   (clk),
      .rst_n (rst_n),
      .evt   (evt),
      .en    (en_q),
      .clr   (irq_clr),
      .pend  (pend),
      .irq   (irq)
   );

   if (PAD_W > 0) begin : g_pad
      assign rp8 = {{PAD_W{1'b0}}, rptr};
      assign wp8 = {{PAD_W{1'b0}}, wptr};
   end else begin : g_nopad
      assign rp8 = rptr;
      assign wp8 = wptr;
   end

   always_comb begin
      reg_rdata = '0;
      if (hit) begin
         reg_rdata[B_PRST]          = prst_busy;
         reg_rdata[B_WBACK]         = 1'b1;
         reg_rdata[B_SOO]           = soo_q;
         reg_rdata[B_WP_LO +: 8]    = wp8;
         reg_rdata[B_RP_LO +: 8]    = rp8;
         reg_rdata[B_IE_CPL]        = en_q[C_CPL];
         reg_rdata[B_IE_EOF]        = en_q[C_EOF];
         reg_rdata[B_IE_STALL]      = en_q[C_STALL];
         reg_rdata[B_IE_IOC]        = en_q[C_IOC];
         reg_rdata[B_IE_ERR]        = en_q[C_ERR];
         reg_rdata[B_START]         = start_q;
      end
   end

   assign eng_run = start_q;
endmodule

// File: rtl/rxring_ctrl_chk.sv
module rxring_ctrl_chk #(
   parameter int PTR_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             soo,
   input logic [PTR_W-1:0] rptr,
   input logic [PTR_W-1:0] wptr,
   input logic             prst_busy,
   input logic             adv_req,
   input logic             ovf_hit,
   input logic             irq,
   input logic             irq_clr,
   input logic             hit,
   input logic [31:0]      reg_rdata
);
   p_prst_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      prst_busy |=> (!prst_busy && rptr == '0 && wptr == '0));

   p_rptr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!adv_req && !prst_busy) |=> $stable(rptr));

   p_rptr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (adv_req && !prst_busy) |=> (rptr == PTR_W'($past(rptr) + 1'b1)));

   p_ovf_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_hit && soo) |=> !start);

   p_fixed_bits_r7: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> (reg_rdata[30] && reg_rdata[28:24] == 5'd0 && !reg_rdata[6] && !reg_rdata[4]));

   p_irq_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !irq_clr) |=> irq);
endmodule

bind rxring_ctrl_reg rxring_ctrl_chk #(.PTR_W(PTR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start_q),
   .soo       (soo_q),
   .rptr      (rptr),
   .wptr      (wptr),
   .prst_busy (prst_busy),
   .adv_req   (adv_req),
   .ovf_hit   (ovf_hit),
   .irq       (irq),
   .irq_clr   (irq_clr),
   .hit       (hit),
   .reg_rdata (reg_rdata)
);

// File: tb/rxring_ctrl_reg_tb.sv
`timescale 1ns/1ps
module rxring_ctrl_reg_tb;
   localparam logic [7:0] IE_CPL = 8'h80, IE_EOF = 8'h20, IE_STALL = 8'h08,
                          IE_IOC = 8'h04, IE_ERR = 8'h02, ST = 8'h01;

   logic clk = 1'b0, rst_n = 1'b0;
   logic reg_we = 0, xfer_busy = 0, desc_done = 0, desc_eop = 0, desc_ioc = 0;
   logic desc_err = 0, desc_eof = 0, dma_err = 0, dma_cpl = 0, irq_clr = 0;
   logic [7:0]  reg_addr = 8'h0C;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic eng_run, irq;
   int n_run = 0, n_fail = 0;
   bit done = 0;
   logic [7:0] exp_rp;

   always #10 clk = ~clk;

   rxring_ctrl_reg u_dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .xfer_busy(xfer_busy),
      .desc_done(desc_done), .desc_eop(desc_eop), .desc_ioc(desc_ioc),
      .desc_err(desc_err), .desc_eof(desc_eof), .dma_err(dma_err),
      .dma_cpl(dma_cpl), .irq_clr(irq_clr), .eng_run(eng_run), .irq(irq)
   );

   function automatic logic [31:0] word(logic prst, logic soo, logic [7:0] wp, logic [7:0] lo);
      return {prst, 1'b0, soo, 5'd0, wp, 8'h00, lo};
   endfunction

   function automatic logic [31:0] rd_exp(logic prst, logic soo, logic [7:0] wp, logic [7:0] rp, logic [7:0] lo);
      return {prst, 1'b1, soo, 5'd0, wp, rp, lo & 8'hAF};
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
      end
   endtask

   task automatic wr(logic [31:0] d);
      @(negedge clk); reg_we = 1; reg_wdata = d;
      @(negedge clk); reg_we = 0;
   endtask

   task automatic desc(logic eop, logic ioc, logic err, logic eof);
      @(negedge clk);
      desc_done = 1; desc_eop = eop; desc_ioc = ioc; desc_err = err; desc_eof = eof;
      @(negedge clk);
      desc_done = 0; desc_eop = 0; desc_ioc = 0; desc_err = 0; desc_eof = 0;
   endtask

   task automatic clr_irq();
      @(negedge clk); irq_clr = 1;
      @(negedge clk); irq_clr = 0;
   endtask

   task automatic ptr_reset();
      wr(word(0, 0, 8'h00, 8'h00));
      wr(word(1, 0, 8'h00, 8'h00));
      @(negedge clk);
   endtask

   task automatic fire(int c);
      case (c)
         0: desc(0, 1, 0, 0);
         1: desc(0, 0, 1, 0);
         2: begin @(negedge clk); dma_err = 1; @(negedge clk); dma_err = 0; end
         3: desc(0, 0, 0, 1);
         default: begin @(negedge clk); dma_cpl = 1; @(negedge clk); dma_cpl = 0; end
      endcase
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic [7:0] masks [5];
      masks = '{IE_IOC, IE_IOC, IE_ERR, IE_EOF, IE_CPL};
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset value and address decode
      chk("R1 reset word", reg_rdata, 32'h4000_0000);
      reg_addr = 8'h08;
      #1 chk("R1 other address", reg_rdata, 32'h0);
      @(negedge clk); reg_we = 1; reg_wdata = 32'h0000_00FF;
      @(negedge clk); reg_we = 0; reg_addr = 8'h0C;
      #1 chk("R1 foreign write", reg_rdata, 32'h4000_0000);

      // R2 / R7 all ones while idle
      wr(32'hFFFF_FFFF);
      chk("R2 R7 flag cycle", reg_rdata, 32'hE0FF_00AF);
      @(negedge clk);
      chk("R2 pointers cleared", reg_rdata, 32'h6000_00AF);
      wr(32'h0);
      clr_irq();
      chk("R10 cleared", {31'd0, irq}, 32'd0);

      // R5 readback
      wr(word(0, 1, 8'h5A, IE_CPL | IE_IOC | ST));
      chk("R5 readback", reg_rdata, rd_exp(0, 1, 8'h5A, 8'h00, IE_CPL | IE_IOC | ST));
      chk("R5 eng_run", {31'd0, eng_run}, 32'd1);

      // R4 consumer index sweep with wrap
      ptr_reset();
      wr(word(0, 0, 8'h00, ST));
      desc(0, 0, 0, 0);
      chk("R4 no eop", {24'd0, reg_rdata[15:8]}, 32'd0);
      exp_rp = 8'h00;
      for (int i = 0; i < 300; i++) begin
         desc(1, 0, 0, 0);
         exp_rp = exp_rp + 8'd1;
         chk("R4 step", {24'd0, reg_rdata[15:8]}, {24'd0, exp_rp});
      end
      wr(word(0, 0, 8'h00, ST) | 32'h0000_FF00);
      chk("R4 sw write rptr", {24'd0, reg_rdata[15:8]}, {24'd0, exp_rp});

      // R3 pointer reset refused while running or busy
      wr(word(1, 0, 8'h00, ST));
      chk("R3 running flag", {31'd0, reg_rdata[31]}, 32'd0);
      @(negedge clk);
      chk("R3 running ptr", {24'd0, reg_rdata[15:8]}, {24'd0, exp_rp});
      wr(word(0, 0, 8'h00, 8'h00));
      desc(1, 0, 0, 0);
      chk("R4 stopped", {24'd0, reg_rdata[15:8]}, {24'd0, exp_rp});
      xfer_busy = 1;
      wr(word(1, 0, 8'h00, 8'h00));
      chk("R3 busy flag", {31'd0, reg_rdata[31]}, 32'd0);
      @(negedge clk);
      chk("R3 busy ptr", {24'd0, reg_rdata[15:8]}, {24'd0, exp_rp});
      xfer_busy = 0;

      // R6 stop on overflow at several distances
      for (int k = 0; k < 4; k++) begin
         automatic int d = (k == 0) ? 1 : (k == 1) ? 2 : (k == 2) ? 5 : 255;
         ptr_reset();
         wr(word(0, 1, 8'(d), ST));
         for (int j = 0; j < d - 1; j++) desc(1, 0, 0, 0);
         chk("R6 still running", {31'd0, eng_run}, 32'd1);
         desc(1, 0, 0, 0);
         chk("R6 stopped", {31'd0, reg_rdata[0]}, 32'd0);
         chk("R6 eng_run low", {31'd0, eng_run}, 32'd0);
         desc(1, 0, 0, 0);
         chk("R6 frozen", {24'd0, reg_rdata[15:8]}, 32'(d));
      end
      ptr_reset();
      wr(word(0, 0, 8'h03, ST));
      repeat (3) desc(1, 0, 0, 0);
      chk("R6 no stop", {31'd0, eng_run}, 32'd1);
      desc(1, 0, 0, 0);
      chk("R6 continues", {24'd0, reg_rdata[15:8]}, 32'd4);

      // R9 per-cause enables
      ptr_reset();
      for (int c = 0; c < 5; c++) begin
         wr(word(0, 0, 8'h40, masks[c] | ST));
         clr_irq();
         fire(c);
         chk("R9 enabled cause", {31'd0, irq}, 32'd1);
         clr_irq();
         chk("R10 clear drop", {31'd0, irq}, 32'd0);
         wr(word(0, 0, 8'h40, (~masks[c] & (IE_CPL | IE_EOF | IE_IOC | IE_ERR)) | ST));
         fire(c);
         chk("R9 disabled cause", {31'd0, irq}, 32'd0);
      end

      // R10 event with clear in the same cycle, and stickiness
      wr(word(0, 0, 8'h40, IE_EOF | ST));
      @(negedge clk);
      desc_done = 1; desc_eof = 1; irq_clr = 1;
      @(negedge clk);
      desc_done = 0; desc_eof = 0; irq_clr = 0;
      chk("R10 set beats clear", {31'd0, irq}, 32'd1);
      repeat (5) @(negedge clk);
      chk("R10 sticky", {31'd0, irq}, 32'd1);
      clr_irq();
      chk("R10 cleared again", {31'd0, irq}, 32'd0);

      // R8 stall on equal pointers
      ptr_reset();
      wr(word(0, 0, 8'h00, IE_STALL));
      @(negedge clk);
      chk("R8 equal raises", {31'd0, irq}, 32'd1);
      wr(word(0, 0, 8'h05, IE_STALL));
      clr_irq();
      repeat (2) @(negedge clk);
      chk("R8 unequal quiet", {31'd0, irq}, 32'd0);

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule